// File: doc/BRIEF.md
# DMA Peripheral Request Handshake Unit

This block connects one peripheral to a DMA channel engine. The peripheral raises single-cycle pulses that ask for a single transfer or a burst transfer. Each accepted pulse goes into a small request queue, and every entry carries a tag for its type. The engine sends commands over a valid/ready interface. Two of these commands make the engine wait for a peripheral request. Each queued entry is either consumed or kept, depending on which wait command meets it at the head of the queue.

Load and store commands can ask for a transfer-done acknowledge. When one does, the unit pulses the acknowledge line back to the peripheral after the matching bus response:
- for a read, the last read data beat;
- for a write, the write response.

A flush command empties the queue and raises a flush request to the peripheral. While the flush is pending, the unit ignores all incoming requests. It stops ignoring them only when the peripheral answers with a flush acknowledge, so both sides restart from a known point. Two sticky flags record errors: a protocol violation and a queue overflow. Only reset clears them.

Top module: `dma_preq_unit`

## Requirements
- R1: Accepted requests are queued in arrival order. Each entry is tagged single (0) or burst (1).
- R2: A wait-any command (op 0) that finds a single entry at the head removes that entry and completes in the same cycle.
- R3: A wait-any command that finds a burst entry at the head completes but leaves the entry queued. Later wait-any commands keep completing on that same entry.
- R4: A wait-burst command (op 1) removes the head entry, whether it is single or burst, and completes in the same cycle.
- R5: While the queue is empty, cmd_ready_o is low for wait-any and wait-burst commands. For every other op it is high.
- R6: A load command (op 3) with cmd_ack_en_i high arms a read acknowledge. xfer_ack_o is then high for exactly one cycle, the cycle after the first cycle with rvalid_i and rlast_i both high, and the arm is cleared. A load with cmd_ack_en_i low disarms it, and beats seen while disarmed give no acknowledge.
- R7: A store command (op 4) with cmd_ack_en_i high arms a write acknowledge. xfer_ack_o is then high for one cycle, the cycle after the first cycle with bvalid_i high, and the arm is cleared. Unarmed responses give no acknowledge.
- R8: A flush command (op 2) always completes. It leaves the queue empty from the next cycle. flush_req_o is high from the next cycle until the cycle after flush_ack_i, and every request arriving in that window is discarded.
- R9: A single request that arrives while an earlier burst request has not yet been removed by a wait-burst command is dropped and sets proto_err_o. proto_err_o stays set until reset.
- R10: A request is dropped and sets ovf_err_o if the queue already holds DEPTH entries (default 4) at the clock edge, even when a pop happens in the same cycle. ovf_err_o stays set until reset.
- R11: Synchronous reset empties the queue and clears xfer_ack_o, flush_req_o, proto_err_o, ovf_err_o and both acknowledge arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_single_i | input | 1 | Single-transfer request pulse from the peripheral |
| req_burst_i | input | 1 | Burst-transfer request pulse from the peripheral |
| cmd_valid_i | input | 1 | Engine command valid |
| cmd_op_i | input | 3 | Command: 0 wait-any, 1 wait-burst, 2 flush, 3 load, 4 store |
| cmd_ack_en_i | input | 1 | The load or store command asks for a peripheral acknowledge |
| cmd_ready_o | output | 1 | Command accepted in this cycle |
| rvalid_i | input | 1 | Read data beat valid from the bus |
| rlast_i | input | 1 | Read beat is the last of its burst |
| bvalid_i | input | 1 | Write response valid from the bus |
| xfer_ack_o | output | 1 | Transfer-done acknowledge to the peripheral |
| flush_req_o | output | 1 | Flush request to the peripheral |
| flush_ack_i | input | 1 | Flush acknowledge from the peripheral |
| proto_err_o | output | 1 | Sticky: single request during an outstanding burst |
| ovf_err_o | output | 1 | Sticky: request dropped because the queue was full |

## Verification
The assertions assume the following about the inputs:
- flush_ack_i is only meaningful while a flush is pending.
- The request pulses and the bus response strobes last one cycle each.
- req_single_i and req_burst_i are never high in the same cycle.

The stimulus keeps within these limits. It never raises both request lines together. It raises flush_ack_i only after a flush command. It drives every input on the falling clock edge, so a command and its op stay stable through the sampling edge.

// File: rtl/dma_preq_pkg.sv
package dma_preq_pkg;

  typedef enum logic [2:0] {
    OP_WAIT_ANY   = 3'd0,
    OP_WAIT_BURST = 3'd1,
    OP_FLUSH      = 3'd2,
    OP_LOAD       = 3'd3,
    OP_STORE      = 3'd4
  } preq_op_e;

  typedef enum logic {
    KIND_SINGLE = 1'b0,
    KIND_BURST  = 1'b1
  } preq_kind_e;

endpackage

// File: rtl/preq_fifo.sv
module preq_fifo
  import dma_preq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       push,
  input  preq_kind_e push_kind,
  input  logic       pop,
  output preq_kind_e head_kind,
  output logic       empty,
  output logic       full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  preq_kind_e     mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  cnt;
  logic           do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_kind;
  end

  assign head_kind = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/preq_intake.sv
module preq_intake
  import dma_preq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_single,
  input  logic       req_burst,
  input  logic       flush_start,
  input  logic       flush_ack,
  input  logic       burst_done,
  input  logic       full,
  output logic       push,
  output preq_kind_e push_kind,
  output logic       flushing,
  output logic       proto_err,
  output logic       ovf_err
);
  logic open_gate, take_b, take_s, viol, wants, burst_pend;

  assign open_gate = !flushing && !flush_start;
  assign take_b    = req_burst && open_gate;
  assign take_s    = req_single && !req_burst && open_gate;
  assign viol      = take_s && burst_pend;
  assign wants     = take_b || (take_s && !viol);
  assign push      = wants && !full;
  assign push_kind = take_b ? KIND_BURST : KIND_SINGLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      flushing   <= 1'b0;
      burst_pend <= 1'b0;
      proto_err  <= 1'b0;
      ovf_err    <= 1'b0;
    end else begin
      if (flush_start)                flushing <= 1'b1;
      else if (flushing && flush_ack) flushing <= 1'b0;

      if (flush_start || burst_done)  burst_pend <= 1'b0;
      else if (take_b && !full)       burst_pend <= 1'b1;

      if (viol)          proto_err <= 1'b1;
      if (wants && full) ovf_err   <= 1'b1;
    end
  end
endmodule

// File: rtl/preq_ack_gen.sv
module preq_ack_gen (
  input  logic clk,
  input  logic rst,
  input  logic load_go,
  input  logic store_go,
  input  logic want_ack,
  input  logic rvalid_i,
  input  logic rlast_i,
  input  logic bvalid_i,
  output logic ack_o
);
  logic rd_arm, wr_arm, rd_end;

  assign rd_end = rvalid_i && rlast_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_arm <= 1'b0;
      wr_arm <= 1'b0;
      ack_o  <= 1'b0;
    end else begin
      ack_o <= (rd_arm && rd_end) || (wr_arm && bvalid_i);
      if (load_go)     rd_arm <= want_ack;
      else if (rd_end) rd_arm <= 1'b0;
      if (store_go)      wr_arm <= want_ack;
      else if (bvalid_i) wr_arm <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_preq_unit.sv
module dma_preq_unit
  import dma_preq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_single_i,
  input  logic       req_burst_i,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_op_i,
  input  logic       cmd_ack_en_i,
  output logic       cmd_ready_o,
  input  logic       rvalid_i,
  input  logic       rlast_i,
  input  logic       bvalid_i,
  output logic       xfer_ack_o,
  output logic       flush_req_o,
  input  logic       flush_ack_i,
  output logic       proto_err_o,
  output logic       ovf_err_o
);
  logic       is_wait, fire, pop, burst_done, flush_start;
  logic       push, fifo_empty, fifo_full;
  preq_kind_e push_kind, head_kind;

  assign is_wait     = (cmd_op_i == OP_WAIT_ANY) || (cmd_op_i == OP_WAIT_BURST);
  assign cmd_ready_o = is_wait ? !fifo_empty : 1'b1;
  assign fire        = cmd_valid_i && cmd_ready_o;
  assign pop         = fire && ((cmd_op_i == OP_WAIT_BURST) ||
                                (cmd_op_i == OP_WAIT_ANY && head_kind == KIND_SINGLE));
  assign burst_done  = fire && (cmd_op_i == OP_WAIT_BURST) && (head_kind == KIND_BURST);
  assign flush_start = fire && (cmd_op_i == OP_FLUSH);

  preq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(flush_start),
    .push(push), .push_kind(push_kind), .pop(pop),
    .head_kind(head_kind), .empty(fifo_empty), .full(fifo_full)
  );

  preq_intake u_intake (
    .clk(clk), .rst(rst),
    .req_single(req_single_i), .req_burst(req_burst_i),
    .flush_start(flush_start), .flush_ack(flush_ack_i),
    .burst_done(burst_done), .full(fifo_full),
    .push(push), .push_kind(push_kind), .flushing(flush_req_o),
    .proto_err(proto_err_o), .ovf_err(ovf_err_o)
  );

  preq_ack_gen u_ack (
    .clk(clk), .rst(rst),
    .load_go(fire && cmd_op_i == OP_LOAD),
    .store_go(fire && cmd_op_i == OP_STORE),
    .want_ack(cmd_ack_en_i),
    .rvalid_i(rvalid_i), .rlast_i(rlast_i), .bvalid_i(bvalid_i),
    .ack_o(xfer_ack_o)
  );
endmodule

// File: rtl/preq_chk.sv
module preq_chk
  import dma_preq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid_i,
  input logic [2:0] cmd_op_i,
  input logic       cmd_ready_o,
  input logic       rvalid_i,
  input logic       rlast_i,
  input logic       bvalid_i,
  input logic       xfer_ack_o,
  input logic       flush_req_o,
  input logic       flush_ack_i,
  input logic       proto_err_o,
  input logic       ovf_err_o,
  input logic       fifo_empty
);
  p_wait_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && fifo_empty &&
     (cmd_op_i == OP_WAIT_ANY || cmd_op_i == OP_WAIT_BURST)) |-> !cmd_ready_o);

  // R6 and R7: an acknowledge always follows a bus completion
  p_ack_after_resp_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_ack_o |-> $past((rvalid_i && rlast_i) || bvalid_i));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_ready_o && cmd_op_i == OP_FLUSH) |=> fifo_empty);

  p_empty_while_flush_r8: assert property (@(posedge clk) disable iff (rst)
    flush_req_o |-> fifo_empty);

  p_flush_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (flush_req_o && !flush_ack_i &&
     !(cmd_valid_i && cmd_op_i == OP_FLUSH)) |=> flush_req_o);

  p_perr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    proto_err_o |=> proto_err_o);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    ovf_err_o |=> ovf_err_o);
endmodule

bind dma_preq_unit preq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .cmd_ready_o(cmd_ready_o), .rvalid_i(rvalid_i), .rlast_i(rlast_i),
  .bvalid_i(bvalid_i), .xfer_ack_o(xfer_ack_o), .flush_req_o(flush_req_o),
  .flush_ack_i(flush_ack_i), .proto_err_o(proto_err_o), .ovf_err_o(ovf_err_o),
  .fifo_empty(fifo_empty)
);

// File: tb/tb_dma_preq_unit.sv
`timescale 1ns/1ps
module tb_dma_preq_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_single_i, req_burst_i, cmd_valid_i, cmd_ack_en_i;
  logic [2:0] cmd_op_i;
  logic       rvalid_i, rlast_i, bvalid_i, flush_ack_i;
  logic       cmd_ready_o, xfer_ack_o, flush_req_o, proto_err_o, ovf_err_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  dma_preq_unit #(.DEPTH(4)) dut (
    .clk(clk), .rst(rst),
    .req_single_i(req_single_i), .req_burst_i(req_burst_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_ack_en_i(cmd_ack_en_i),
    .cmd_ready_o(cmd_ready_o),
    .rvalid_i(rvalid_i), .rlast_i(rlast_i), .bvalid_i(bvalid_i),
    .xfer_ack_o(xfer_ack_o), .flush_req_o(flush_req_o), .flush_ack_i(flush_ack_i),
    .proto_err_o(proto_err_o), .ovf_err_o(ovf_err_o)
  );

  // [19:16] requirement, then rs rb | cv | op | ack_en | rv rl bv fa,
  // then expected ready xfer_ack flush_req proto_err ovf_err (seen before the edge)
  localparam int NV = 44;
  localparam logic [19:0] VEC [NV] = '{
    {4'd11, 11'b00_0_000_0_0000, 5'b00000},  // R11 idle after reset
    {4'd1,  11'b10_0_000_0_0000, 5'b00000},  // R1 single in
    {4'd1,  11'b01_0_000_0_0000, 5'b10000},  // R1 burst in
    {4'd2,  11'b00_1_000_0_0000, 5'b10000},  // R2 wait-any pops single
    {4'd3,  11'b00_1_000_0_0000, 5'b10000},  // R3 wait-any keeps burst
    {4'd4,  11'b00_1_001_0_0000, 5'b10000},  // R4 wait-burst pops burst
    {4'd5,  11'b00_1_000_0_0000, 5'b00000},  // R5 stall any
    {4'd5,  11'b00_1_001_0_0000, 5'b00000},  // R5 stall burst
    {4'd1,  11'b10_0_000_0_0000, 5'b00000},
    {4'd4,  11'b00_1_001_0_0000, 5'b10000},  // R4 wait-burst drops single
    {4'd4,  11'b00_0_000_0_0000, 5'b00000},
    {4'd6,  11'b00_1_011_1_0000, 5'b10000},  // R6 load with ack
    {4'd6,  11'b00_0_000_0_1000, 5'b00000},
    {4'd6,  11'b00_0_000_0_1100, 5'b00000},
    {4'd6,  11'b00_0_000_0_0000, 5'b01000},
    {4'd6,  11'b00_0_000_0_1100, 5'b00000},
    {4'd6,  11'b00_0_000_0_0000, 5'b00000},
    {4'd6,  11'b00_1_011_0_0000, 5'b10000},  // R6 load no ack
    {4'd6,  11'b00_0_000_0_1100, 5'b00000},
    {4'd6,  11'b00_0_000_0_0000, 5'b00000},
    {4'd7,  11'b00_1_100_1_0000, 5'b10000},  // R7 store with ack
    {4'd7,  11'b00_0_000_0_0010, 5'b00000},
    {4'd7,  11'b00_0_000_0_0000, 5'b01000},
    {4'd7,  11'b00_0_000_0_0010, 5'b00000},
    {4'd7,  11'b00_0_000_0_0000, 5'b00000},
    {4'd9,  11'b01_0_000_0_0000, 5'b00000},  // R9 burst outstanding
    {4'd9,  11'b10_0_000_0_0000, 5'b10000},  // R9 illegal single
    {4'd9,  11'b00_0_000_0_0000, 5'b10010},
    {4'd3,  11'b00_1_000_0_0000, 5'b10010},
    {4'd4,  11'b00_1_001_0_0000, 5'b10010},
    {4'd9,  11'b00_0_000_0_0000, 5'b00010},  // R9 single was dropped
    {4'd10, 11'b10_0_000_0_0000, 5'b00010},  // R10 fill
    {4'd10, 11'b10_0_000_0_0000, 5'b10010},
    {4'd10, 11'b10_0_000_0_0000, 5'b10010},
    {4'd10, 11'b10_0_000_0_0000, 5'b10010},
    {4'd10, 11'b10_0_000_0_0000, 5'b10010},  // R10 fifth: dropped
    {4'd10, 11'b00_0_000_0_0000, 5'b10011},
    {4'd8,  11'b00_1_010_0_0000, 5'b10011},  // R8 flush
    {4'd8,  11'b10_0_000_0_0000, 5'b00111},
    {4'd8,  11'b01_0_000_0_0000, 5'b00111},
    {4'd8,  11'b00_0_000_0_0001, 5'b00111},  // R8 flush ack
    {4'd8,  11'b00_0_000_0_0000, 5'b00011},
    {4'd8,  11'b10_0_000_0_0000, 5'b00011},
    {4'd8,  11'b00_0_000_0_0000, 5'b10011}
  };

  task automatic drive(input logic [10:0] f);
    {req_single_i, req_burst_i, cmd_valid_i, cmd_op_i, cmd_ack_en_i,
     rvalid_i, rlast_i, bvalid_i, flush_ack_i} = f;
  endtask

  task automatic check(input int rq, input int idx, input logic [4:0] exp);
    logic [4:0] got;
    got = {cmd_ready_o, xfer_ack_o, flush_req_o, proto_err_o, ovf_err_o};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d step %0d: got %b expected %b (rdy ack frq perr ovf)",
               rq, idx, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    drive('0);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    drive('0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][15:5]);
      #1;
      check(int'(VEC[i][19:16]), i, VEC[i][4:0]);
      @(negedge clk);
    end

    // R11: reset clears sticky flags and the queued single
    do_reset();
    drive('0);
    #1 check(11, 100, 5'b00000);

    // R10: full at the edge still overflows despite a same-cycle pop
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      drive(11'b10_0_000_0_0000);
    end
    @(negedge clk);
    drive(11'b10_1_000_0_0000);
    #1 check(10, 101, 5'b10000);
    @(negedge clk);
    drive('0);
    #1 check(10, 102, 5'b10001);

    // R8 then R11: reset during a pending flush drops the flush request
    @(negedge clk);
    drive(11'b00_1_010_0_0000);
    @(negedge clk);
    drive('0);
    #1 check(8, 103, 5'b00101);
    do_reset();
    #1 check(11, 104, 5'b00000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule